// File: doc/BRIEF.md
# Thread Interrupt Pending Priority Logic

This block holds the interrupt priority state of one hardware thread, as seen by an interrupt presenter. Routed events arrive tagged with a priority number. Each event is recorded in a small pending buffer that has one bit per priority level. From that buffer the block computes the most favoured pending priority on every cycle. It compares that priority against the thread's current priority threshold and drives an exception line toward the core.

Software controls the block through a plain register port:
- It writes the threshold to open or close the thread to interrupts.
- It issues an acknowledge to take the interrupt being presented.

An acknowledge returns the delivered priority in the same cycle. On the following edge it removes that priority from the pending buffer and raises the threshold to it, so equal and less favoured work stays masked until software lowers it again. Only one priority-management ring is modelled.

Top module: `thr_irq_prio_ctx`

## Requirements
- R1: After reset the pending buffer is 0, the threshold is 0x00, the pending priority reads 0xFF and the exception output is low.
- R2: An event with priority p in 0..7 sets bit (7 - p) of the pending buffer, visible on the cycle after the event is sampled.
- R3: An event whose priority is 8 or greater leaves the pending buffer unchanged.
- R4: The pending priority is, in the same cycle, the lowest priority number whose bit is set in the pending buffer, and 0xFF when the buffer is empty.
- R5: The exception output is high exactly when the pending priority is numerically lower than the threshold, and it follows both without a clock delay.
- R6: A threshold write takes effect on the next cycle. A value of 0xFF lets every pending priority through, and a value of 0x00 blocks all of them.
- R7: An acknowledge while the exception output is high returns the pending priority on ack_prio in the same cycle. On the next cycle that priority's buffer bit is clear and the threshold equals that priority.
- R8: An acknowledge while the exception output is low returns 0xFF and changes neither the buffer nor the threshold.
- R9: When an event and an acknowledge name the same priority in one cycle, that priority's buffer bit is still set afterwards.
- R10: When an acknowledge and a threshold write happen in one cycle, the threshold takes the acknowledged priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A routed event is offered this cycle |
| evt_prio | input | 8 | Priority of the offered event |
| cppr_wr | input | 1 | Threshold write strobe |
| cppr_wdata | input | 8 | Threshold value to write |
| ack_req | input | 1 | Acknowledge request |
| ack_prio | output | 8 | Priority delivered by the acknowledge, 0xFF if none |
| pend_buf | output | 8 | Pending buffer, bit (7 - p) for priority p |
| pend_prio | output | 8 | Most favoured pending priority, 0xFF if none |
| cppr | output | 8 | Current priority threshold |
| exc_o | output | 1 | Exception request to the thread |

## Verification
The bench first exercises the bit inversion. A design that stored priority p at bit p would report the wrong pending buffer and would choose the least favoured priority as the winner. It then drives out-of-range priorities, which a careless decoder would alias onto a real bit. It also tests a threshold equal to the pending priority, where a less-or-equal compare would wrongly raise the exception.

The same-cycle collisions are tested directly:
- An event arriving at the priority being acknowledged must survive. A clear-after-set ordering would lose it.
- A threshold write arriving with an acknowledge must not win. Otherwise the thread could be re-interrupted at the priority it is already handling.

An acknowledge with nothing presentable must return 0xFF and leave all state alone.

// File: rtl/thr_prio_pkg.sv
package thr_prio_pkg;
   localparam int unsigned PRIO_W = 8;
   typedef logic [PRIO_W-1:0] prio_t;
   localparam prio_t PRIO_NONE = '1;
endpackage

// File: rtl/thr_prio_enc.sv
module thr_prio_enc
   import thr_prio_pkg::*;
#(
   parameter int unsigned NUM_PRIO = 8
) (
   input  logic [NUM_PRIO-1:0] buf_i,
   output prio_t               prio_o
);
   // Bit (NUM_PRIO-1-p) holds priority p; the lowest p found wins.
   always_comb begin
      prio_o = PRIO_NONE;
      for (int i = NUM_PRIO-1; i >= 0; i--) begin
         if (buf_i[NUM_PRIO-1-i]) prio_o = PRIO_W'(i);
      end
   end
endmodule

// File: rtl/thr_pend_buf.sv
module thr_pend_buf
   import thr_prio_pkg::*;
#(
   parameter int unsigned NUM_PRIO = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_vld,
   input  prio_t               set_prio,
   input  logic                clr_vld,
   input  prio_t               clr_prio,
   output logic [NUM_PRIO-1:0] buf_q
);
   for (genvar b = 0; b < NUM_PRIO; b++) begin : g_bit
      localparam prio_t BIT_PRIO = PRIO_W'(NUM_PRIO-1-b);
      logic set_hit, clr_hit;
      assign set_hit = set_vld && (set_prio == BIT_PRIO);
      assign clr_hit = clr_vld && (clr_prio == BIT_PRIO);
      always_ff @(posedge clk) begin
         if (!rst_n) buf_q[b] <= 1'b0;
         else        buf_q[b] <= set_hit | (buf_q[b] & ~clr_hit);
      end
   end
endmodule

// File: rtl/thr_cppr_reg.sv
module thr_cppr_reg
   import thr_prio_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ack_vld,
   input  prio_t ack_prio,
   input  logic  wr_vld,
   input  prio_t wr_data,
   output prio_t cppr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       cppr_q <= '0;
      else if (ack_vld) cppr_q <= ack_prio;
      else if (wr_vld)  cppr_q <= wr_data;
   end
endmodule

// File: rtl/thr_irq_prio_ctx.sv
module thr_irq_prio_ctx
   import thr_prio_pkg::*;
#(
   parameter int unsigned NUM_PRIO = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_valid,
   input  logic [7:0]          evt_prio,
   input  logic                cppr_wr,
   input  logic [7:0]          cppr_wdata,
   input  logic                ack_req,
   output logic [7:0]          ack_prio,
   output logic [NUM_PRIO-1:0] pend_buf,
   output logic [7:0]          pend_prio,
   output logic [7:0]          cppr,
   output logic                exc_o
);
   if (NUM_PRIO < 1 || NUM_PRIO > (2**PRIO_W) - 1) begin : g_bad_num_prio
      $error("NUM_PRIO must leave the all-ones code free");
   end
   if (PRIO_W != 8) begin : g_bad_width
      $error("port widths assume 8-bit priorities");
   end

   logic ack_fire;

   thr_pend_buf #(.NUM_PRIO(NUM_PRIO)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vld  (evt_valid),
      .set_prio (evt_prio),
      .clr_vld  (ack_fire),
      .clr_prio (pend_prio),
      .buf_q    (pend_buf)
   );

   thr_prio_enc #(.NUM_PRIO(NUM_PRIO)) u_enc (
      .buf_i  (pend_buf),
      .prio_o (pend_prio)
   );

   thr_cppr_reg u_cppr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_vld  (ack_fire),
      .ack_prio (pend_prio),
      .wr_vld   (cppr_wr),
      .wr_data  (cppr_wdata),
      .cppr_q   (cppr)
   );

   assign exc_o    = (pend_prio < cppr);
   assign ack_fire = ack_req && exc_o;
   assign ack_prio = ack_fire ? pend_prio : PRIO_NONE;
endmodule

// File: rtl/thr_irq_prio_chk.sv
module thr_irq_prio_chk #(
   parameter int unsigned NUM_PRIO = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                evt_valid,
   input logic [7:0]          evt_prio,
   input logic                cppr_wr,
   input logic [7:0]          cppr_wdata,
   input logic                ack_req,
   input logic [7:0]          ack_prio,
   input logic [NUM_PRIO-1:0] pend_buf,
   input logic [7:0]          pend_prio,
   input logic [7:0]          cppr,
   input logic                exc_o
);
   localparam int unsigned IW = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;

   a_r2_sets_inverted_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_prio < NUM_PRIO) |=>
         pend_buf[IW'(NUM_PRIO-1) - $past(evt_prio[IW-1:0])]);

   a_r3_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_prio >= NUM_PRIO && !ack_req) |=> $stable(pend_buf));

   a_r4_empty_reads_none: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_buf == '0) |-> (pend_prio == 8'hFF));

   a_r6_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cppr == 8'h00) |-> !exc_o);

   a_r6_open_presents: assert property (@(posedge clk) disable iff (!rst_n)
      (cppr == 8'hFF && pend_buf != '0) |-> exc_o);

   a_r7_ack_raises_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && exc_o) |=> (cppr == $past(pend_prio)) && !exc_o);

   a_r8_idle_ack_none: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !exc_o) |-> (ack_prio == 8'hFF));

   a_r8_idle_ack_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !exc_o && !cppr_wr && !evt_valid) |=>
         $stable(pend_buf) && $stable(cppr));

   a_r10_ack_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && exc_o && cppr_wr) |=> (cppr == $past(ack_prio)));
endmodule

bind thr_irq_prio_ctx thr_irq_prio_chk #(.NUM_PRIO(NUM_PRIO)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_prio(evt_prio),
   .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .ack_req(ack_req),
   .ack_prio(ack_prio), .pend_buf(pend_buf), .pend_prio(pend_prio),
   .cppr(cppr), .exc_o(exc_o)
);

// File: tb/tb_thr_irq_prio_ctx.sv
module tb_thr_irq_prio_ctx;
   localparam time CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_valid = 1'b0;
   logic [7:0] evt_prio = '0;
   logic       cppr_wr = 1'b0;
   logic [7:0] cppr_wdata = '0;
   logic       ack_req = 1'b0;
   logic [7:0] ack_prio, pend_prio, cppr;
   logic [7:0] pend_buf;
   logic       exc_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] buf_e;
      logic [7:0] prio_e;
      logic [7:0] cppr_e;
      logic       exc_e;
      logic [7:0] ack_e;
      string      tag;
   } item_t;

   item_t sb_q[$];

   // independent reference state
   logic [7:0] m_buf = '0;
   logic [7:0] m_cppr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thr_irq_prio_ctx dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_prio(evt_prio),
      .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .ack_req(ack_req),
      .ack_prio(ack_prio), .pend_buf(pend_buf), .pend_prio(pend_prio),
      .cppr(cppr), .exc_o(exc_o)
   );

   function automatic logic [7:0] m_prio(input logic [7:0] b);
      for (int p = 0; p < 8; p++) if (b[7-p]) return 8'(p);
      return 8'hFF;
   endfunction

   task automatic step(input bit ev, input logic [7:0] ep, input bit wr,
                       input logic [7:0] wd, input bit ak, input string tag);
      item_t it;
      logic [7:0] mp;
      logic       mx;
      @(negedge clk);
      evt_valid = ev; evt_prio = ep; cppr_wr = wr; cppr_wdata = wd; ack_req = ak;
      #1;
      mp = m_prio(m_buf);
      mx = (mp < m_cppr);
      it.buf_e = m_buf; it.prio_e = mp; it.cppr_e = m_cppr; it.exc_e = mx;
      it.ack_e = (ak && mx) ? mp : 8'hFF; it.tag = tag;
      sb_q.push_back(it);
      if (ak && mx) begin
         m_buf[7-mp] = 1'b0;
         m_cppr = mp;
      end else if (wr) begin
         m_cppr = wd;
      end
      if (ev && ep < 8) m_buf[7-ep] = 1'b1;
   endtask

   task automatic idle(input string tag);
      step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, tag);
   endtask

   // monitor: compares each expected item against the ports
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (pend_buf !== it.buf_e || pend_prio !== it.prio_e ||
                cppr !== it.cppr_e || exc_o !== it.exc_e || ack_prio !== it.ack_e) begin
               failures++;
               $display("FAIL %s: buf=%h prio=%h cppr=%h exc=%b ack=%h expected buf=%h prio=%h cppr=%h exc=%b ack=%h",
                        it.tag, pend_buf, pend_prio, cppr, exc_o, ack_prio,
                        it.buf_e, it.prio_e, it.cppr_e, it.exc_e, it.ack_e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1 reset state");
      step(1, 8'd3, 0, 0, 0, "R2 event p3");
      idle("R2 bit 4 set, R6 zero threshold blocks");
      step(1, 8'd9, 0, 0, 0, "R3 event p9");
      idle("R3 buffer unchanged");
      step(1, 8'hFF, 0, 0, 0, "R3 event pFF");
      step(1, 8'd6, 0, 0, 0, "R3 buffer unchanged");
      idle("R4 lowest number wins");
      step(0, 0, 1, 8'd5, 0, "R6 write 5");
      idle("R5 exc 3<5");
      step(0, 0, 1, 8'd3, 0, "R5 write 3");
      idle("R5 equal threshold no exc");
      step(0, 0, 1, 8'hFF, 0, "R6 write FF");
      idle("R6 FF opens all");
      step(0, 0, 0, 0, 1, "R7 ack returns 3");
      idle("R7 bit cleared threshold 3");
      step(0, 0, 0, 0, 1, "R8 idle ack FF");
      idle("R8 no state change");
      step(0, 0, 1, 8'hFF, 0, "R6 reopen");
      step(1, 8'd6, 0, 0, 1, "R9 ack with same-prio event");
      idle("R9 bit kept");
      step(0, 0, 1, 8'd7, 0, "R5 write 7");
      step(0, 0, 1, 8'd0, 1, "R10 ack with write");
      idle("R10 ack wins threshold");
      for (int p = 0; p < 8; p++) step(1, 8'(p), 0, 0, 0, "R2 fill all");
      for (int p = 0; p < 8; p++) begin
         step(0, 0, 1, 8'hFF, 0, "R6 reopen");
         step(0, 0, 0, 0, 1, "R7 drain ack");
      end
      idle("R4 empty reads FF");
      @(negedge clk);
      #3;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule